// File: doc/BRIEF.md
# Paged Ternary IPv4 Lookup Engine

This block resolves a 32-bit IPv4 destination address to a next-hop index by longest-prefix match. It uses small register-based ternary arrays and does the work in two pipeline steps. In the first step, the upper octet of the address chooses a segment, and a bank of ternary selectors ("cubes") is compared against the address. The lowest-numbered selector that matches enables exactly one page. When no selector matches, the short-prefix bucket is enabled instead.

In the second step, only the enabled page or the bucket is searched. A page holds only the low 24 address bits of each route. The bucket holds full 32-bit ternary words for prefixes shorter than one octet. The engine reports a hit flag, a next-hop index and the number of valid entries that took part in the search. A single write port loads selectors, page entries and bucket entries.

Addresses are accepted one per cycle under a valid/ready handshake. Software is expected to store routes inside a page or the bucket in descending prefix-length order. With that ordering, the first match is also the longest match.

Top module: `lpm_paged_engine`

## Requirements
- R1: In reset and on the first cycle after it, `out_valid`, `out_hit`, `out_nh` and `out_enabled` are zero. `in_ready` is high from the first clock edge after reset is released.
- R2: An address accepted on a rising edge (with `in_valid` and `in_ready` high) produces its result on the following rising edge, with `out_valid` high. Back-to-back addresses are accepted one per cycle, and their results come out in order.
- R3: Selector i matches when two conditions hold. First, address bits [31:24] equal its stored segment octet; this comparison is always exact, whatever the mask. Second, the low 24 bits agree wherever the stored mask bit is 1. Among the matching selectors, the lowest index enables page i.
- R4: When any selector matches, only the selected page is searched. A page miss then gives `out_hit`=0 even if the bucket holds a matching route.
- R5: When no selector matches, only the bucket is searched, with a full 32-bit ternary compare.
- R6: Within the searched page or the bucket, the lowest-index valid matching entry supplies `out_nh`.
- R7: A lookup with no matching entry in the searched region returns `out_hit`=0 and `out_nh`=0.
- R8: Write port encoding: `wr_target` 0 = selector, 1 = page entry, 2 = bucket entry. The value 3 changes nothing. A page entry's index is page*PAGE_DEPTH + slot. A mask bit of 1 means the bit is compared. `wr_valid`=0 removes the entry.
- R9: Page entries compare only address bits [23:0]. The upper octet written into a page entry has no effect.
- R10: `out_enabled` equals the number of valid entries in the page or bucket that was searched, and it never exceeds max(PAGE_DEPTH, BUCKET_DEPTH).
- R11: A write applied on one rising edge is seen by every lookup accepted on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Engine can take an address |
| in_addr | input | ADDR_W | Destination address |
| wr_en | input | 1 | Write strobe |
| wr_target | input | 2 | 0 selector, 1 page entry, 2 bucket entry |
| wr_index | input | IDX_W | Entry index |
| wr_value | input | ADDR_W | Ternary value bits |
| wr_mask | input | ADDR_W | Ternary care bits (1 = compare) |
| wr_nh | input | NH_W | Next-hop index stored with the entry |
| wr_valid | input | 1 | Valid bit written to the entry |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | A route matched |
| out_nh | output | NH_W | Next-hop index, zero on miss |
| out_enabled | output | CNT_W | Valid entries searched for this lookup |

## Verification
The bench targets several corner cases.

- Two selectors overlap in the same segment. If the priority were reversed, the wider selector would win and the lookup would land in the wrong page.
- An address hits a selector but misses its page while the bucket holds a default route. A design that fell back to the bucket would report a hit where a miss is required.
- A selector is written with a fully open mask. A design that honoured that mask on the segment octet would capture addresses from other segments.
- Duplicate page entries and a /32-above-/24 ordering check the lowest-index rule. A write on the cycle just before an accepted lookup, a deleted entry and a write to the unused target code check the write semantics and the enabled-entry count.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      TGT_CUBE   = 2'd0,
      TGT_PAGE   = 2'd1,
      TGT_BUCKET = 2'd2,
      TGT_NONE   = 2'd3
   } lpm_target_e;

   function automatic int lpm_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lpm_cube_sel.sv
// First-level selector: exact segment octet plus ternary low field,
// lowest index wins, one-hot page enable out.
module lpm_cube_sel #(
   parameter int ADDR_W    = 32,
   parameter int SEG_W     = 8,
   parameter int NUM_CUBES = 4,
   parameter int IW        = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           key,
   input  logic                        we,
   input  logic [IW-1:0]               widx,
   input  logic [ADDR_W-1:0]           wval,
   input  logic [ADDR_W-SEG_W-1:0]     wcare,
   input  logic                        wvld,
   output logic [NUM_CUBES-1:0]        sel,
   output logic                        any
);
   localparam int LOW_W = ADDR_W - SEG_W;

   logic [SEG_W-1:0]     seg_q  [NUM_CUBES];
   logic [LOW_W-1:0]     val_q  [NUM_CUBES];
   logic [LOW_W-1:0]     care_q [NUM_CUBES];
   logic [NUM_CUBES-1:0] vld_q;
   logic [NUM_CUBES-1:0] match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (we) begin
         vld_q[widx] <= wvld;
      end
   end

   always_ff @(posedge clk) begin
      if (we) begin
         seg_q[widx]  <= wval[ADDR_W-1:LOW_W];
         val_q[widx]  <= wval[LOW_W-1:0];
         care_q[widx] <= wcare;
      end
   end

   for (genvar c = 0; c < NUM_CUBES; c++) begin : g_cube
      assign match[c] = vld_q[c]
                     && (key[ADDR_W-1:LOW_W] == seg_q[c])
                     && (((key[LOW_W-1:0] ^ val_q[c]) & care_q[c]) == '0);
   end

   always_comb begin
      sel = '0;
      for (int c = NUM_CUBES - 1; c >= 0; c--) begin
         if (match[c]) begin
            sel    = '0;
            sel[c] = 1'b1;
         end
      end
   end

   assign any = |match;

endmodule

// File: rtl/lpm_tern_bank.sv
// Ternary entry bank with search enable, first-match priority and
// a count of the valid entries it searched.
module lpm_tern_bank #(
   parameter int W     = 24,
   parameter int DEPTH = 8,
   parameter int NH_W  = 6,
   parameter int CNT_W = 4,
   parameter int IW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [W-1:0]     key,
   input  logic             we,
   input  logic [IW-1:0]    widx,
   input  logic [W-1:0]     wval,
   input  logic [W-1:0]     wcare,
   input  logic [NH_W-1:0]  wnh,
   input  logic             wvld,
   output logic             hit,
   output logic [NH_W-1:0]  nh,
   output logic [CNT_W-1:0] cnt
);
   logic [W-1:0]     val_q  [DEPTH];
   logic [W-1:0]     care_q [DEPTH];
   logic [NH_W-1:0]  nh_q   [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] match;
   logic [CNT_W-1:0] total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (we) begin
         vld_q[widx] <= wvld;
      end
   end

   always_ff @(posedge clk) begin
      if (we) begin
         val_q[widx]  <= wval;
         care_q[widx] <= wcare;
         nh_q[widx]   <= wnh;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign match[i] = en && vld_q[i]
                     && (((key ^ val_q[i]) & care_q[i]) == '0);
   end

   always_comb begin
      hit = 1'b0;
      nh  = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit = 1'b1;
            nh  = nh_q[i];
         end
      end
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < DEPTH; i++) begin
         total = total + CNT_W'(vld_q[i]);
      end
   end

   assign cnt = en ? total : '0;

endmodule

// File: rtl/lpm_paged_engine.sv
module lpm_paged_engine
   import lpm_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int SEG_W        = 8,
   parameter int NUM_PAGES    = 4,
   parameter int PAGE_DEPTH   = 8,
   parameter int BUCKET_DEPTH = 8,
   parameter int NH_W         = 6,
   localparam int IDX_W = $clog2(lpm_max(NUM_PAGES * PAGE_DEPTH, BUCKET_DEPTH)),
   localparam int CNT_W = $clog2(lpm_max(PAGE_DEPTH, BUCKET_DEPTH) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              wr_en,
   input  logic [1:0]        wr_target,
   input  logic [IDX_W-1:0]  wr_index,
   input  logic [ADDR_W-1:0] wr_value,
   input  logic [ADDR_W-1:0] wr_mask,
   input  logic [NH_W-1:0]   wr_nh,
   input  logic              wr_valid,
   output logic              out_valid,
   output logic              out_hit,
   output logic [NH_W-1:0]   out_nh,
   output logic [CNT_W-1:0]  out_enabled
);
   localparam int LOW_W   = ADDR_W - SEG_W;
   localparam int SLOT_W  = $clog2(PAGE_DEPTH);
   localparam int CUBE_IW = $clog2(NUM_PAGES);
   localparam int BK_IW   = $clog2(BUCKET_DEPTH);

   if (PAGE_DEPTH > 256 || PAGE_DEPTH < 2 || (1 << SLOT_W) != PAGE_DEPTH) begin : g_bad_page
      $error("PAGE_DEPTH must be a power of two in 2..256");
   end
   if (BUCKET_DEPTH < 2 || (1 << BK_IW) != BUCKET_DEPTH) begin : g_bad_bucket
      $error("BUCKET_DEPTH must be a power of two of at least 2");
   end
   if (NUM_PAGES < 2 || SEG_W < 1 || SEG_W >= ADDR_W) begin : g_bad_geom
      $error("need two or more pages and 0 < SEG_W < ADDR_W");
   end

   // handshake and stage 1
   logic                 rdy_q;
   logic                 accept;
   logic                 s1_valid;
   logic [ADDR_W-1:0]    s1_addr;
   logic [NUM_PAGES-1:0] s1_sel;
   logic                 s1_any;
   logic [NUM_PAGES-1:0] cube_sel;
   logic                 cube_any;
   logic                 cube_we;

   assign in_ready = rdy_q;
   assign accept   = in_valid && rdy_q;
   assign cube_we  = wr_en && (wr_target == TGT_CUBE)
                  && (32'(wr_index) < 32'(NUM_PAGES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
      end else begin
         rdy_q <= 1'b1;
      end
   end

   lpm_cube_sel #(
      .ADDR_W(ADDR_W), .SEG_W(SEG_W), .NUM_CUBES(NUM_PAGES), .IW(CUBE_IW)
   ) u_cubes (
      .clk   (clk),
      .rst_n (rst_n),
      .key   (in_addr),
      .we    (cube_we),
      .widx  (wr_index[CUBE_IW-1:0]),
      .wval  (wr_value),
      .wcare (wr_mask[LOW_W-1:0]),
      .wvld  (wr_valid),
      .sel   (cube_sel),
      .any   (cube_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_addr  <= '0;
         s1_sel   <= '0;
         s1_any   <= 1'b0;
      end else begin
         s1_valid <= accept;
         if (accept) begin
            s1_addr <= in_addr;
            s1_sel  <= cube_sel;
            s1_any  <= cube_any;
         end
      end
   end

   // stage 2: one enabled region among pages and bucket
   logic [NUM_PAGES:0] bank_en;
   logic               r_hit [NUM_PAGES+1];
   logic [NH_W-1:0]    r_nh  [NUM_PAGES+1];
   logic [CNT_W-1:0]   r_cnt [NUM_PAGES+1];

   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      logic pg_we;
      assign bank_en[p] = s1_valid && s1_any && s1_sel[p];
      assign pg_we      = wr_en && (wr_target == TGT_PAGE)
                       && (int'(wr_index[IDX_W-1:SLOT_W]) == p);

      lpm_tern_bank #(
         .W(LOW_W), .DEPTH(PAGE_DEPTH), .NH_W(NH_W), .CNT_W(CNT_W), .IW(SLOT_W)
      ) u_page (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (bank_en[p]),
         .key   (s1_addr[LOW_W-1:0]),
         .we    (pg_we),
         .widx  (wr_index[SLOT_W-1:0]),
         .wval  (wr_value[LOW_W-1:0]),
         .wcare (wr_mask[LOW_W-1:0]),
         .wnh   (wr_nh),
         .wvld  (wr_valid),
         .hit   (r_hit[p]),
         .nh    (r_nh[p]),
         .cnt   (r_cnt[p])
      );
   end

   logic bk_we;
   assign bank_en[NUM_PAGES] = s1_valid && !s1_any;
   assign bk_we = wr_en && (wr_target == TGT_BUCKET)
               && (32'(wr_index) < 32'(BUCKET_DEPTH));

   lpm_tern_bank #(
      .W(ADDR_W), .DEPTH(BUCKET_DEPTH), .NH_W(NH_W), .CNT_W(CNT_W), .IW(BK_IW)
   ) u_bucket (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (bank_en[NUM_PAGES]),
      .key   (s1_addr),
      .we    (bk_we),
      .widx  (wr_index[BK_IW-1:0]),
      .wval  (wr_value),
      .wcare (wr_mask),
      .wnh   (wr_nh),
      .wvld  (wr_valid),
      .hit   (r_hit[NUM_PAGES]),
      .nh    (r_nh[NUM_PAGES]),
      .cnt   (r_cnt[NUM_PAGES])
   );

   logic             hit_c;
   logic [NH_W-1:0]  nh_c;
   logic [CNT_W-1:0] cnt_c;

   always_comb begin
      hit_c = 1'b0;
      nh_c  = '0;
      cnt_c = '0;
      for (int b = 0; b <= NUM_PAGES; b++) begin
         hit_c = hit_c | r_hit[b];
         nh_c  = nh_c  | r_nh[b];
         cnt_c = cnt_c | r_cnt[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_hit     <= 1'b0;
         out_nh      <= '0;
         out_enabled <= '0;
      end else begin
         out_valid   <= s1_valid;
         out_hit     <= hit_c;
         out_nh      <= nh_c;
         out_enabled <= cnt_c;
      end
   end

endmodule

// File: rtl/lpm_paged_engine_chk.sv
module lpm_paged_engine_chk #(
   parameter int NUM_PAGES    = 4,
   parameter int PAGE_DEPTH   = 8,
   parameter int BUCKET_DEPTH = 8,
   parameter int NH_W         = 6,
   parameter int CNT_W        = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_hit,
   input logic [NH_W-1:0]    out_nh,
   input logic [CNT_W-1:0]   out_enabled,
   input logic [NUM_PAGES:0] bank_en
);
   localparam int BOUND = (PAGE_DEPTH > BUCKET_DEPTH) ? PAGE_DEPTH : BUCKET_DEPTH;

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid && in_ready, 2));

   // R4
   one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_en));

   // R7
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hit) |-> (out_nh == '0));

   // R10
   enable_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(out_enabled) <= BOUND));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_hit && out_enabled == '0));

endmodule

bind lpm_paged_engine lpm_paged_engine_chk #(
   .NUM_PAGES(NUM_PAGES), .PAGE_DEPTH(PAGE_DEPTH), .BUCKET_DEPTH(BUCKET_DEPTH),
   .NH_W(NH_W), .CNT_W(CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_hit     (out_hit),
   .out_nh      (out_nh),
   .out_enabled (out_enabled),
   .bank_en     (bank_en)
);

// File: tb/tb_lpm_paged_engine.sv
`timescale 1ns/1ps
module tb_lpm_paged_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_addr = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_target = '0;
   logic [4:0]  wr_index = '0;
   logic [31:0] wr_value = '0;
   logic [31:0] wr_mask = '0;
   logic [5:0]  wr_nh = '0;
   logic        wr_valid = 1'b0;
   logic        out_valid;
   logic        out_hit;
   logic [5:0]  out_nh;
   logic [3:0]  out_enabled;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   lpm_paged_engine dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .wr_en(wr_en), .wr_target(wr_target),
      .wr_index(wr_index), .wr_value(wr_value), .wr_mask(wr_mask),
      .wr_nh(wr_nh), .wr_valid(wr_valid), .out_valid(out_valid),
      .out_hit(out_hit), .out_nh(out_nh), .out_enabled(out_enabled)
   );

   // {addr, hit, nh, enabled}
   localparam int NV = 9;
   localparam logic [42:0] VEC [NV] = '{
      {32'h0A01_0203, 1'b1, 6'd5,  4'd3},  // R6 /32 before /24
      {32'h0A01_02FF, 1'b1, 6'd6,  4'd3},  // R3 page0 /24
      {32'h0A01_FF00, 1'b1, 6'd7,  4'd3},  // R3 page0 /16
      {32'h0A02_0304, 1'b1, 6'd9,  4'd1},  // R3 cube1, R9
      {32'h0A03_0000, 1'b0, 6'd0,  4'd1},  // R4 page miss, no bucket fallback
      {32'hC0A8_0105, 1'b1, 6'd12, 4'd2},  // R6 duplicate, lower wins
      {32'hC0A9_0000, 1'b1, 6'd1,  4'd2},  // R5 bucket default
      {32'hAC1F_0001, 1'b1, 6'd20, 4'd2},  // R5 bucket /12
      {32'h0B01_0203, 1'b1, 6'd1,  4'd2}   // R3 segment exact
   };

   task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got {valid,hit,nh,en}=%h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] t, input logic [4:0] idx, input logic [31:0] v,
                     input logic [31:0] m, input logic [5:0] nh, input logic vl);
      @(negedge clk);
      wr_en = 1'b1; wr_target = t; wr_index = idx;
      wr_value = v; wr_mask = m; wr_nh = nh; wr_valid = vl;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // called at a negedge; result sampled two edges after acceptance
   task automatic look(input string req, input logic [31:0] a, input logic h,
                       input logic [5:0] nh, input logic [3:0] en);
      in_valid = 1'b1; in_addr = a;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check(req, {out_valid, out_hit, out_nh, out_enabled}, {1'b1, h, nh, en});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", {out_valid, out_hit, out_nh, out_enabled}, 12'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {out_valid, out_hit, out_nh, out_enabled}, 12'h0);
      tests++;
      if (in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R1: in_ready=%b expected 1", in_ready);
      end

      // R8 table load: selectors, pages, bucket
      wr(2'd0, 5'd0, 32'h0A01_0000, 32'hFFFF_0000, 6'd0, 1'b1);
      wr(2'd0, 5'd1, 32'h0A00_0000, 32'h0000_0000, 6'd0, 1'b1);
      wr(2'd0, 5'd2, 32'hC0A8_0000, 32'hFFFF_0000, 6'd0, 1'b1);
      wr(2'd1, 5'd0, 32'h0001_0203, 32'h00FF_FFFF, 6'd5, 1'b1);
      wr(2'd1, 5'd1, 32'h0001_0200, 32'h00FF_FF00, 6'd6, 1'b1);
      wr(2'd1, 5'd2, 32'h0001_0000, 32'h00FF_0000, 6'd7, 1'b1);
      wr(2'd1, 5'd8, 32'hEE02_0000, 32'hFFFF_0000, 6'd9, 1'b1);
      wr(2'd1, 5'd16, 32'h00A8_0100, 32'h00FF_FF00, 6'd12, 1'b1);
      wr(2'd1, 5'd17, 32'h00A8_0100, 32'h00FF_FF00, 6'd13, 1'b1);
      wr(2'd2, 5'd0, 32'hAC10_0000, 32'hFFF0_0000, 6'd20, 1'b1);
      wr(2'd2, 5'd1, 32'h0000_0000, 32'h0000_0000, 6'd1, 1'b1);

      // R2 streamed table, one address per cycle
      for (int i = 0; i < NV + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            check($sformatf("R2 vector %0d", i - 2),
                  {out_valid, out_hit, out_nh, out_enabled},
                  {1'b1, VEC[i-2][10:0]});
         end
         if (i < NV) begin
            in_valid = 1'b1; in_addr = VEC[i][42:11];
         end else begin
            in_valid = 1'b0;
         end
      end

      // R8 target code 3 changes nothing
      wr(2'd3, 5'd0, 32'h0A01_0203, 32'hFFFF_FFFF, 6'd33, 1'b0);
      look("R8 unused target, page", 32'h0A01_0203, 1'b1, 6'd5, 4'd3);
      look("R8 unused target, bucket", 32'h0808_0808, 1'b1, 6'd1, 4'd2);

      // R11 write just before the accepting edge is seen
      wr(2'd1, 5'd0, 32'h0, 32'h0, 6'd0, 1'b0);
      look("R11 deleted /32", 32'h0A01_0203, 1'b1, 6'd6, 4'd2);

      // R7 remove bucket default, then miss
      wr(2'd2, 5'd1, 32'h0, 32'h0, 6'd0, 1'b0);
      look("R7 bucket miss", 32'h0808_0808, 1'b0, 6'd0, 4'd1);

      // R9 page entry upper octet ignored
      wr(2'd0, 5'd3, 32'h3000_0000, 32'h0000_0000, 6'd0, 1'b1);
      wr(2'd1, 5'd24, 32'h5512_3456, 32'hFFFF_FFFF, 6'd30, 1'b1);
      look("R9 low field only", 32'h3012_3456, 1'b1, 6'd30, 4'd1);

      // R10 enabled count idle after traffic
      @(negedge clk);
      check("R10 idle count", {out_valid, out_hit, out_nh, out_enabled}, 12'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule